// File: doc/BRIEF.md
# Entropy Word Packer

This block gathers 32-bit entropy words arriving one at a time and assembles them into 256-bit values for two separate consumers. The first consumer is a directly readable random value. The second is the seed for a local pseudo-random generator. Each consumer has its own word input, its own completion handshake from the clock-crossing logic, a 256-bit output and a one-cycle valid strobe. A single flush input clears the state of both consumers.

Once eight words have been packed, a path holds its value and refuses further words until the crossing logic acknowledges completion. A per-path wait counter measures how long the completed value has been waiting. An acknowledgement that arrives too late produces a timeout pulse. A word that arrives while a path is blocked produces an overrun pulse.

The random path delivers its value on the first commit cycle after the acknowledgement is sampled. The seed path delivers at the same edge that samples its acknowledgement.

Top module: `entropy_word_packer`

## Requirements
- R1: On the random path, the k-th accepted word (k = 0..7) occupies bits [32k+31:32k] of the delivered 256-bit value, so the first word lands in the least significant bits.
- R2: The edge that samples the eighth accepted word raises the path's pending output, and the word counter returns to zero, so the next batch again starts at bit 0.
- R3: While a path is pending, an incoming word is not stored. A one-cycle overrun pulse for that path follows the edge that sampled the word.
- R4: On the seed path, 64-bit lane i takes word 2i in its low half and word 2i+1 in its high half. Lane i is delivered in bits [64i+63:64i].
- R5: The wait counter is 0 in the first cycle that pending is high and grows by one per cycle. An acknowledgement sampled with a count of 6 or more gives a one-cycle timeout pulse after that edge, and the value is still delivered. A count of 5 or less gives no pulse.
- R6: A random-path acknowledgement does not deliver at its own edge. The value is delivered at the first later edge at which commit is high. That edge also clears pending.
- R7: A seed-path acknowledgement sampled while pending delivers the seed and clears pending at that same edge.
- R8: Flush clears both accumulators, both word counters, both pending flags and both wait counters. Partly gathered words are discarded.
- R9: Each delivery raises the path's valid output for exactly one cycle, together with the new value.
- R10: Flush takes priority over words and acknowledgements in the same cycle. The word is discarded with no overrun pulse, and the acknowledgement produces no delivery.
- R11: An acknowledgement while a path is not pending has no effect: no valid strobe and no timeout pulse.
- R12: After reset, the pending, valid, overrun and timeout outputs are low and both values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Clears the state of both paths |
| commit | input | 1 | Commit cycle; enables random-path delivery |
| rnd_word_valid | input | 1 | Random-path word present |
| rnd_word | input | 32 | Random-path word |
| rnd_ack | input | 1 | Random-path completion acknowledgement |
| rnd_pending | output | 1 | Random path complete and blocked |
| rnd_value | output | 256 | Last delivered random value |
| rnd_valid | output | 1 | One-cycle strobe on a random delivery |
| rnd_overrun | output | 1 | Word arrived while random path blocked |
| rnd_timeout | output | 1 | Random acknowledgement came too late |
| seed_word_valid | input | 1 | Seed-path word present |
| seed_word | input | 32 | Seed-path word |
| seed_ack | input | 1 | Seed-path completion acknowledgement |
| seed_pending | output | 1 | Seed path complete and blocked |
| seed_value | output | 256 | Last delivered seed |
| seed_valid | output | 1 | One-cycle strobe on a seed delivery |
| seed_overrun | output | 1 | Word arrived while seed path blocked |
| seed_timeout | output | 1 | Seed acknowledgement came too late |

## Verification
A corrupted word counter shows up at the pending output within the same batch: pending rises after too few or too many words, and the delivered value has its words rotated. A stale accumulator or a lost lane half becomes visible only at the next delivery, as wrong bits in the 256-bit value. An off-by-one wait counter shows as a timeout pulse that appears or disappears at the 5/6 boundary, one cycle after the acknowledgement. Flush or priority faults show as a too-early pending rise or a spurious overrun in the following cycles.

// File: rtl/entropy_word_packer.sv
module entropy_word_packer #(
  parameter int WORD_W     = 32,
  parameter int WORDS      = 8,
  parameter int WAIT_LIMIT = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      commit,
  input  logic                      rnd_word_valid,
  input  logic [WORD_W-1:0]         rnd_word,
  input  logic                      rnd_ack,
  output logic                      rnd_pending,
  output logic [WORD_W*WORDS-1:0]   rnd_value,
  output logic                      rnd_valid,
  output logic                      rnd_overrun,
  output logic                      rnd_timeout,
  input  logic                      seed_word_valid,
  input  logic [WORD_W-1:0]         seed_word,
  input  logic                      seed_ack,
  output logic                      seed_pending,
  output logic [WORD_W*WORDS-1:0]   seed_value,
  output logic                      seed_valid,
  output logic                      seed_overrun,
  output logic                      seed_timeout
);
  localparam int VAL_W  = WORD_W * WORDS;
  localparam int CNT_W  = $clog2(WORDS);
  localparam int WAIT_W = $clog2(WAIT_LIMIT + 1);
  localparam int LANES  = WORDS / 2;
  localparam int LANE_W = 2 * WORD_W;
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(WORDS - 1);
  localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(WAIT_LIMIT);

  // random path
  logic [VAL_W-1:0]  r_acc;
  logic [CNT_W-1:0]  r_cnt;
  logic              r_done;
  logic [WAIT_W-1:0] r_wait;

  wire r_take   = rnd_word_valid && !rnd_pending && !flush;
  wire r_last   = r_cnt == LAST_IDX;
  wire r_ack_ok = rnd_ack && rnd_pending && !r_done && !flush;
  wire r_xfer   = r_done && commit && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_acc       <= '0;
      r_cnt       <= '0;
      r_done      <= 1'b0;
      r_wait      <= '0;
      rnd_pending <= 1'b0;
      rnd_value   <= '0;
      rnd_valid   <= 1'b0;
      rnd_overrun <= 1'b0;
      rnd_timeout <= 1'b0;
    end else begin
      rnd_valid   <= r_xfer;
      rnd_overrun <= rnd_word_valid && rnd_pending && !flush;
      rnd_timeout <= r_ack_ok && (r_wait >= WAIT_MAX);
      if (flush) begin
        r_acc       <= '0;
        r_cnt       <= '0;
        r_done      <= 1'b0;
        r_wait      <= '0;
        rnd_pending <= 1'b0;
      end else begin
        if (r_take) begin
          r_acc[r_cnt*WORD_W +: WORD_W] <= rnd_word;
          r_cnt <= r_last ? '0 : r_cnt + 1'b1;
          if (r_last) rnd_pending <= 1'b1;
        end
        if (rnd_pending && !r_done && r_wait != WAIT_MAX)
          r_wait <= r_wait + 1'b1;
        if (r_ack_ok)
          r_done <= 1'b1;
        if (r_xfer) begin
          rnd_value   <= r_acc;
          r_acc       <= '0;
          r_done      <= 1'b0;
          r_wait      <= '0;
          rnd_pending <= 1'b0;
        end
      end
    end
  end

  // seed path
  logic [LANE_W-1:0] s_lane [LANES];
  logic [CNT_W-1:0]  s_cnt;
  logic [WAIT_W-1:0] s_wait;

  wire s_take = seed_word_valid && !seed_pending && !flush;
  wire s_last = s_cnt == LAST_IDX;
  wire s_xfer = seed_ack && seed_pending && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) s_lane[i] <= '0;
      s_cnt        <= '0;
      s_wait       <= '0;
      seed_pending <= 1'b0;
      seed_value   <= '0;
      seed_valid   <= 1'b0;
      seed_overrun <= 1'b0;
      seed_timeout <= 1'b0;
    end else begin
      seed_valid   <= s_xfer;
      seed_overrun <= seed_word_valid && seed_pending && !flush;
      seed_timeout <= s_xfer && (s_wait >= WAIT_MAX);
      if (flush) begin
        for (int i = 0; i < LANES; i++) s_lane[i] <= '0;
        s_cnt        <= '0;
        s_wait       <= '0;
        seed_pending <= 1'b0;
      end else begin
        if (s_take) begin
          s_lane[s_cnt[CNT_W-1:1]][s_cnt[0]*WORD_W +: WORD_W] <= seed_word;
          s_cnt <= s_last ? '0 : s_cnt + 1'b1;
          if (s_last) seed_pending <= 1'b1;
        end
        if (seed_pending && s_wait != WAIT_MAX)
          s_wait <= s_wait + 1'b1;
        if (s_xfer) begin
          for (int i = 0; i < LANES; i++) begin
            seed_value[i*LANE_W +: LANE_W] <= s_lane[i];
            s_lane[i] <= '0;
          end
          s_wait       <= '0;
          seed_pending <= 1'b0;
        end
      end
    end
  end

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_pending && !flush && !r_xfer |=> $stable(r_acc)); // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rnd_pending && !seed_pending && r_cnt == '0 && s_cnt == '0); // R8
  AST_RND_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_ack && rnd_pending && !r_done && !flush |=> !rnd_valid); // R6
  AST_SEED_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ack && seed_pending && !flush |=> seed_valid && !seed_pending); // R7
  AST_RND_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_valid |=> !rnd_valid); // R9
  AST_SEED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |=> !seed_valid); // R9
  AST_TIMEOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    seed_timeout |-> $past(seed_ack)); // R5
endmodule

// File: tb/test_entropy_word_packer.sv
`timescale 1ns/1ps
module test_entropy_word_packer;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, commit = 1'b1;
  logic rnd_word_valid = 1'b0, rnd_ack = 1'b0, seed_word_valid = 1'b0, seed_ack = 1'b0;
  logic [31:0] rnd_word = '0, seed_word = '0;
  logic rnd_pending, rnd_valid, rnd_overrun, rnd_timeout;
  logic seed_pending, seed_valid, seed_overrun, seed_timeout;
  logic [255:0] rnd_value, seed_value;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  entropy_word_packer i_entropy_word_packer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .commit(commit),
    .rnd_word_valid(rnd_word_valid), .rnd_word(rnd_word), .rnd_ack(rnd_ack),
    .rnd_pending(rnd_pending), .rnd_value(rnd_value), .rnd_valid(rnd_valid),
    .rnd_overrun(rnd_overrun), .rnd_timeout(rnd_timeout),
    .seed_word_valid(seed_word_valid), .seed_word(seed_word), .seed_ack(seed_ack),
    .seed_pending(seed_pending), .seed_value(seed_value), .seed_valid(seed_valid),
    .seed_overrun(seed_overrun), .seed_timeout(seed_timeout));

  // high nibble: idle cycles before ack; low nibble: cycles commit held low
  localparam logic [7:0] TBL [5] = '{8'h00, 8'h51, 8'h63, 8'h72, 8'h08};

  function automatic logic [31:0] wv(input int b, input int j);
    return 32'(b * 32'h01000193 + j * 32'h9E3779B9 + 32'h5A5A0000);
  endfunction

  function automatic logic [255:0] expv(input int b);
    logic [255:0] v;
    for (int j = 0; j < 8; j++) v[32*j +: 32] = wv(b, j);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_rnd(input int b, input int n);
    for (int j = 0; j < n; j++) begin
      rnd_word_valid = 1'b1; rnd_word = wv(b, j); tick();
    end
    rnd_word_valid = 1'b0;
  endtask

  task automatic push_seed(input int b, input int n);
    for (int j = 0; j < n; j++) begin
      seed_word_valid = 1'b1; seed_word = wv(b, j); tick();
    end
    seed_word_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(!rnd_pending && !seed_pending && !rnd_valid && !seed_valid, "R12 flags", 0, 0);
    chk(!rnd_overrun && !rnd_timeout && !seed_overrun && !seed_timeout, "R12 errors", 0, 0);
    chk(rnd_value == '0 && seed_value == '0, "R12 values", rnd_value | seed_value, 0);

    // table-driven batches on both paths
    for (int t = 0; t < 5; t++) begin
      automatic int k = int'(TBL[t][7:4]);
      automatic int d = int'(TBL[t][3:0]);
      push_rnd(t + 1, 7);
      chk(!rnd_pending, "R2 not after 7", rnd_pending, 0);
      push_rnd(t + 1, 1);
      // word 7 was from base t+1 index 0 above; redo cleanly below
      flush = 1'b1; tick(); flush = 1'b0;
      push_rnd(t + 1, 8);
      chk(rnd_pending, "R2 pending after 8", rnd_pending, 1);
      repeat (k) tick();
      commit = 1'b0;
      rnd_ack = 1'b1; tick(); rnd_ack = 1'b0;
      chk(rnd_timeout == (k >= 6), "R5 rnd timeout", rnd_timeout, k >= 6);
      chk(!rnd_valid, "R6 not on ack edge", rnd_valid, 0);
      for (int c = 0; c < d; c++) begin
        tick();
        chk(!rnd_valid && rnd_pending, "R6 waits for commit", rnd_valid, 0);
      end
      commit = 1'b1; tick();
      chk(rnd_valid && !rnd_pending, "R6 delivered", rnd_valid, 1);
      chk(rnd_value == expv(t + 1), "R1 packing", rnd_value, expv(t + 1));
      tick();
      chk(!rnd_valid, "R9 one-cycle strobe", rnd_valid, 0);

      push_seed(t + 11, 8);
      chk(seed_pending, "R2 seed pending", seed_pending, 1);
      repeat (k) tick();
      seed_ack = 1'b1; tick(); seed_ack = 1'b0;
      chk(seed_valid && !seed_pending, "R7 seed delivered", seed_valid, 1);
      chk(seed_timeout == (k >= 6), "R5 seed timeout", seed_timeout, k >= 6);
      chk(seed_value == expv(t + 11), "R4 lane packing", seed_value, expv(t + 11));
      tick();
      chk(!seed_valid, "R9 seed strobe", seed_valid, 0);
    end

    // R3 overrun while pending
    push_rnd(40, 8);
    rnd_word_valid = 1'b1; rnd_word = 32'hDEADBEEF; tick(); rnd_word_valid = 1'b0;
    chk(rnd_overrun, "R3 rnd overrun pulse", rnd_overrun, 1);
    tick();
    chk(!rnd_overrun, "R3 pulse one cycle", rnd_overrun, 0);
    rnd_ack = 1'b1; tick(); rnd_ack = 1'b0; tick();
    chk(rnd_value == expv(40), "R3 word not stored", rnd_value, expv(40));
    push_seed(41, 8);
    seed_word_valid = 1'b1; seed_word = 32'hCAFEF00D; tick(); seed_word_valid = 1'b0;
    chk(seed_overrun, "R3 seed overrun", seed_overrun, 1);
    seed_ack = 1'b1; tick(); seed_ack = 1'b0;
    chk(seed_value == expv(41), "R3 seed not stored", seed_value, expv(41));

    // R8 flush discards partial words
    push_rnd(50, 3); push_seed(51, 5);
    flush = 1'b1; tick(); flush = 1'b0;
    push_rnd(52, 7); push_seed(53, 7);
    chk(!rnd_pending && !seed_pending, "R8 counters cleared", {rnd_pending, seed_pending}, 0);
    push_rnd(52, 1); push_seed(53, 1);
    chk(rnd_pending && seed_pending, "R8 pending after 8", {rnd_pending, seed_pending}, 3);
    flush = 1'b1; tick(); flush = 1'b0;
    chk(!rnd_pending && !seed_pending, "R8 flush clears pending", {rnd_pending, seed_pending}, 0);

    // R11 ack while idle
    rnd_ack = 1'b1; seed_ack = 1'b1; tick(); rnd_ack = 1'b0; seed_ack = 1'b0; tick();
    chk(!rnd_valid && !seed_valid && !rnd_timeout && !seed_timeout, "R11 idle ack ignored",
        {rnd_valid, seed_valid}, 0);

    // R10 flush beats word and ack
    rnd_word_valid = 1'b1; rnd_word = 32'h11111111; flush = 1'b1; tick();
    rnd_word_valid = 1'b0; flush = 1'b0;
    push_rnd(60, 7);
    chk(!rnd_pending, "R10 word dropped under flush", rnd_pending, 0);
    push_rnd(60, 1);
    rnd_word_valid = 1'b1; flush = 1'b1; tick(); rnd_word_valid = 1'b0; flush = 1'b0;
    chk(!rnd_overrun, "R10 no overrun under flush", rnd_overrun, 0);
    push_seed(61, 8);
    seed_ack = 1'b1; flush = 1'b1; tick(); seed_ack = 1'b0; flush = 1'b0;
    chk(!seed_valid && !seed_pending, "R10 ack dropped under flush", seed_valid, 0);
    chk(seed_value == expv(41), "R10 seed value kept", seed_value, expv(41));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule